// File: doc/BRIEF.md
# Transparent FIFO Vertex Cache

This block sits in a geometry front end between a stream of vertex index lookups and a memory read port that returns whole vertex records. Each lookup carries a 16-bit vertex index. When the index is held in the cache, the stored record comes back one cycle after the lookup is accepted. When it is not held, the block issues a read to memory and stalls further lookups. It writes the returned record into the slot chosen by a first-in-first-out insertion pointer and returns the same record to the requester.

The request stream carries no allocation hints, so the cache alone decides what to keep. A hit never changes an entry's age. Vertices that an earlier strip shared therefore leave the cache in the order they were inserted. Responses come back in request order. Lookups are grouped three per triangle, and the block reports the hit or miss pattern of each triangle as a 3-bit vector. Two saturating counters track hits and misses, and a clear input zeroes both.

Top module: `vtx_fifo_cache`

## Requirements
- R1: After reset every slot is invalid, both counters read zero, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. The first lookup of any index is a miss.
- R2: After a miss is accepted, `mem_req_valid` is 1 from the next cycle with `mem_req_index` equal to the missing index, held stable, and `req_ready` stays 0 until the cycle in which `mem_rsp_valid` is 1.
- R3: A lookup that hits gives `rsp_valid`=1 and `rsp_miss`=0 in the cycle after acceptance, with `rsp_data` equal to the record stored for that index, and raises no memory read.
- R4: A miss response appears in the cycle after `mem_rsp_valid`, with `rsp_miss`=1 and `rsp_data` equal to the returned memory record.
- R5: Fills go to slots in insertion order, and the insertion pointer advances by one modulo ENTRIES. The record replaced on a miss is always the oldest inserted, however many hits it has had since.
- R6: Tags compare the full 16-bit index. Indices that differ only in bit 15 never alias.
- R7: `hit_count` increments by one per hit response and `miss_count` by one per miss response. Each stops at its all-ones value.
- R8: `clr_stats`=1 sets both counters to zero at the next clock edge, taking precedence over an increment.
- R9: Responses are numbered from reset in groups of three. On the third response of each group `rsp_face_done`=1 and `rsp_face_miss` bit i holds the miss flag of the i-th response of the group (bit 0 first). On all other responses `rsp_face_done`=0.
- R10: Exactly one response is produced per accepted lookup, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_stats | input | 1 | Zeroes the hit and miss counters |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Cache can accept a lookup |
| req_index | input | IDX_W | Vertex index to look up |
| rsp_valid | output | 1 | Response record valid for one cycle |
| rsp_data | output | WORDS*WORD_W | Vertex record |
| rsp_miss | output | 1 | Response came from memory |
| rsp_face_done | output | 1 | Third response of a triangle |
| rsp_face_miss | output | 3 | Miss flags of the triangle's three lookups |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_index | output | IDX_W | Index to read |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | WORDS*WORD_W | Record read from memory |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
The bench sends strip-like triangles whose vertices overlap with earlier ones, so hits and misses mix within each face vector. It sends index pairs that differ only in the top bit, to separate full tag compares from partial ones. It fills the cache and then keeps hitting the oldest entry before forcing an eviction, which separates FIFO replacement from LRU replacement. A long run of hits on one index, followed by a clear, exercises saturation and the precedence of the clear.

// File: rtl/vc_pkg.sv
package vc_pkg;

  typedef enum logic {
    ST_LOOK = 1'b0,
    ST_FILL = 1'b1
  } vc_state_e;

  // Ring advance used by the insertion pointer.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned n);
    return (p + 1 == n) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/vc_tag_match.sv
module vc_tag_match #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 16,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES*IDX_W-1:0] tag_flat,
  input  logic [ENTRIES-1:0]       slot_valid,
  input  logic [IDX_W-1:0]         key,
  output logic [ENTRIES-1:0]       hit_vec,
  output logic                     hit,
  output logic [SLOT_W-1:0]        hit_slot
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = slot_valid[g] && (tag_flat[g*IDX_W +: IDX_W] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_slot = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_slot = hit_slot | SLOT_W'(i);
    end
  end

endmodule

// File: rtl/vc_store.sv
module vc_store
  import vc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 16,
  parameter int REC_W   = 256,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_tag,
  input  logic [REC_W-1:0]         wr_rec,
  input  logic [SLOT_W-1:0]        rd_slot,
  output logic [REC_W-1:0]         rd_rec,
  output logic [ENTRIES*IDX_W-1:0] tag_flat,
  output logic [ENTRIES-1:0]       slot_valid,
  output logic [SLOT_W-1:0]        ins_ptr
);

  logic [REC_W-1:0] rec_mem [ENTRIES];
  logic [IDX_W-1:0] tag_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid <= '0;
      ins_ptr    <= '0;
    end else if (wr_en) begin
      slot_valid[ins_ptr] <= 1'b1;
      ins_ptr <= SLOT_W'(ring_next(int'(ins_ptr), ENTRIES));
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      rec_mem[ins_ptr] <= wr_rec;
      tag_mem[ins_ptr] <= wr_tag;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tag
    assign tag_flat[g*IDX_W +: IDX_W] = tag_mem[g];
  end

  assign rd_rec = rec_mem[rd_slot];

endmodule

// File: rtl/vc_sat_counter.sv
module vc_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else if (inc)      count <= bump(count);
  end

endmodule

// File: rtl/vtx_fifo_cache.sv
module vtx_fifo_cache
  import vc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 16,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 8,
  parameter int CNT_W   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_stats,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [IDX_W-1:0]        req_index,
  output logic                    rsp_valid,
  output logic [WORDS*WORD_W-1:0] rsp_data,
  output logic                    rsp_miss,
  output logic                    rsp_face_done,
  output logic [2:0]              rsp_face_miss,
  output logic                    mem_req_valid,
  output logic [IDX_W-1:0]        mem_req_index,
  input  logic                    mem_rsp_valid,
  input  logic [WORDS*WORD_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]        hit_count,
  output logic [CNT_W-1:0]        miss_count
);

  localparam int REC_W  = WORDS * WORD_W;
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  vc_state_e state;
  logic [IDX_W-1:0] pend_idx;

  // Named internal events for the checker.
  logic                     lookup_fire;
  logic                     lookup_hit;
  logic                     hit_fire;
  logic                     fill_fire;
  logic                     resp_evt;
  logic [ENTRIES-1:0]       hit_vec;
  logic [SLOT_W-1:0]        hit_slot;
  logic [SLOT_W-1:0]        victim_slot;
  logic [REC_W-1:0]         hit_rec;
  logic [ENTRIES*IDX_W-1:0] tag_flat;
  logic [ENTRIES-1:0]       slot_valid;

  logic [1:0] lane;
  logic [1:0] lane_acc;

  assign req_ready     = (state == ST_LOOK);
  assign lookup_fire   = req_valid && req_ready;
  assign hit_fire      = lookup_fire && lookup_hit;
  assign fill_fire     = (state == ST_FILL) && mem_rsp_valid;
  assign resp_evt      = hit_fire || fill_fire;
  assign mem_req_valid = (state == ST_FILL);
  assign mem_req_index = pend_idx;

  vc_tag_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
    .tag_flat   (tag_flat),
    .slot_valid (slot_valid),
    .key        (req_index),
    .hit_vec    (hit_vec),
    .hit        (lookup_hit),
    .hit_slot   (hit_slot)
  );

  vc_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .REC_W(REC_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (fill_fire),
    .wr_tag     (pend_idx),
    .wr_rec     (mem_rsp_data),
    .rd_slot    (hit_slot),
    .rd_rec     (hit_rec),
    .tag_flat   (tag_flat),
    .slot_valid (slot_valid),
    .ins_ptr    (victim_slot)
  );

  vc_sat_counter #(.CNT_W(CNT_W)) u_hits (
    .clk (clk), .rst_n (rst_n), .clr (clr_stats), .inc (hit_fire), .count (hit_count)
  );

  vc_sat_counter #(.CNT_W(CNT_W)) u_misses (
    .clk (clk), .rst_n (rst_n), .clr (clr_stats), .inc (fill_fire), .count (miss_count)
  );

  // Control state and pending index.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_LOOK;
      pend_idx <= '0;
    end else begin
      case (state)
        ST_LOOK: if (lookup_fire && !lookup_hit) begin
          state    <= ST_FILL;
          pend_idx <= req_index;
        end
        ST_FILL: if (mem_rsp_valid) state <= ST_LOOK;
        default: state <= ST_LOOK;
      endcase
    end
  end

  // Response register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= resp_evt;
      if (resp_evt) begin
        rsp_miss <= fill_fire;
        rsp_data <= fill_fire ? mem_rsp_data : hit_rec;
      end
    end
  end

  // Per-triangle miss vector.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane          <= 2'd0;
      lane_acc      <= 2'b00;
      rsp_face_done <= 1'b0;
      rsp_face_miss <= 3'b000;
    end else begin
      rsp_face_done <= 1'b0;
      if (resp_evt) begin
        if (lane == 2'd2) begin
          rsp_face_miss <= {fill_fire, lane_acc};
          rsp_face_done <= 1'b1;
          lane          <= 2'd0;
          lane_acc      <= 2'b00;
        end else begin
          lane_acc[lane[0]] <= fill_fire;
          lane              <= lane + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 16,
  parameter int CNT_W   = 32,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr_stats,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_miss,
  input logic               mem_req_valid,
  input logic [IDX_W-1:0]   mem_req_index,
  input logic               mem_rsp_valid,
  input logic [CNT_W-1:0]   hit_count,
  input logic [CNT_W-1:0]   miss_count,
  input logic               hit_fire,
  input logic               fill_fire,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [SLOT_W-1:0]  victim_slot
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  a_r2_stall_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  a_r2_index_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_index)));

  a_r3_hit_response: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> (rsp_valid && !rsp_miss));

  a_r4_miss_response: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> (rsp_valid && rsp_miss));

  a_r5_ptr_ring: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> (victim_slot == (($past(victim_slot) == SLOT_W'(ENTRIES - 1)) ?
                                   SLOT_W'(0) : SLOT_W'($past(victim_slot) + 1'b1))));

  a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r7_hit_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count == TOP && !clr_stats) |=> (hit_count == TOP));

  a_r7_miss_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count == TOP && !clr_stats) |=> (miss_count == TOP));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stats |=> (hit_count == '0 && miss_count == '0));

  a_r10_resp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(hit_fire) || $past(fill_fire)));

endmodule

bind vtx_fifo_cache vc_checker #(
  .ENTRIES (ENTRIES),
  .IDX_W   (IDX_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr_stats     (clr_stats),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_miss      (rsp_miss),
  .mem_req_valid (mem_req_valid),
  .mem_req_index (mem_req_index),
  .mem_rsp_valid (mem_rsp_valid),
  .hit_count     (hit_count),
  .miss_count    (miss_count),
  .hit_fire      (hit_fire),
  .fill_fire     (fill_fire),
  .hit_vec       (hit_vec),
  .victim_slot   (victim_slot)
);

// File: tb/vtx_fifo_cache_bench.sv
`timescale 1ns/1ps
module vtx_fifo_cache_bench;

  localparam int ENTRIES = 16;
  localparam int IDX_W   = 16;
  localparam int WORD_W  = 32;
  localparam int WORDS   = 8;
  localparam int CNT_W   = 6;
  localparam int REC_W   = WORDS * WORD_W;
  localparam int CMAX    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_stats = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [IDX_W-1:0] req_index = '0;
  logic rsp_valid, rsp_miss, rsp_face_done;
  logic [2:0] rsp_face_miss;
  logic [REC_W-1:0] rsp_data;
  logic mem_req_valid;
  logic [IDX_W-1:0] mem_req_index;
  logic mem_rsp_valid = 1'b0;
  logic [REC_W-1:0] mem_rsp_data = '0;
  logic [CNT_W-1:0] hit_count, miss_count;

  always #2 clk = ~clk;

  vtx_fifo_cache #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .WORD_W(WORD_W),
                   .WORDS(WORDS), .CNT_W(CNT_W)) u_vtx_fifo_cache (
    .clk, .rst_n, .clr_stats, .req_valid, .req_ready, .req_index,
    .rsp_valid, .rsp_data, .rsp_miss, .rsp_face_done, .rsp_face_miss,
    .mem_req_valid, .mem_req_index, .mem_rsp_valid, .mem_rsp_data,
    .hit_count, .miss_count
  );

  int checks = 0;
  int errors = 0;

  // Scoreboard queues.
  logic [REC_W-1:0] exp_rec_q[$];
  logic             exp_miss_q[$];
  logic             exp_done_q[$];
  logic [2:0]       exp_vec_q[$];
  string            exp_tag_q[$];
  logic [IDX_W-1:0] exp_mem_q[$];

  logic [IDX_W-1:0] model_q[$];
  int n_hit = 0;
  int n_miss = 0;
  int lane = 0;
  logic [1:0] acc = 2'b00;
  int mem_reqs = 0;

  function automatic logic [REC_W-1:0] rec_of(input logic [IDX_W-1:0] idx);
    logic [REC_W-1:0] r;
    for (int w = 0; w < WORDS; w++) r[w*WORD_W +: WORD_W] = {idx ^ 16'h3C00, 16'(w * 17 + 1)};
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [REC_W-1:0] act, input logic [REC_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_has(input logic [IDX_W-1:0] idx);
    foreach (model_q[i]) if (model_q[i] == idx) return 1'b1;
    return 1'b0;
  endfunction

  // Driver: called at a negedge, returns at a negedge.
  task automatic lookup(input logic [IDX_W-1:0] idx, input string tag);
    logic m;
    m = !model_has(idx);
    if (m) begin
      model_q.push_back(idx);
      if (model_q.size() > ENTRIES) void'(model_q.pop_front());
      exp_mem_q.push_back(idx);
      n_miss++;
    end else n_hit++;
    exp_rec_q.push_back(rec_of(idx));
    exp_miss_q.push_back(m);
    exp_tag_q.push_back(tag);
    if (lane == 2) begin
      exp_done_q.push_back(1'b1);
      exp_vec_q.push_back({m, acc});
      lane = 0; acc = 2'b00;
    end else begin
      exp_done_q.push_back(1'b0);
      exp_vec_q.push_back(3'b000);
      acc[lane] = m;
      lane++;
    end
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_index = idx;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Memory responder with varying latency.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [IDX_W-1:0] e;
        e = (exp_mem_q.size() > 0) ? exp_mem_q.pop_front() : '1;
        check(mem_req_index == e, "R2", "memory read index", REC_W'(mem_req_index), REC_W'(e));
        for (int d = 0; d < mem_reqs % 3; d++) begin
          check(!req_ready && mem_req_valid, "R2", "stall while fetching",
                REC_W'({req_ready, mem_req_valid}), REC_W'(2'b01));
          @(negedge clk);
        end
        mem_reqs++;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rec_of(mem_req_index);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // Monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (exp_rec_q.size() == 0) begin
          check(1'b0, "R10", "unexpected response", REC_W'(1), REC_W'(0));
        end else begin
          logic [REC_W-1:0] er; logic em; logic ed; logic [2:0] ev; string t;
          er = exp_rec_q.pop_front(); em = exp_miss_q.pop_front();
          ed = exp_done_q.pop_front(); ev = exp_vec_q.pop_front(); t = exp_tag_q.pop_front();
          check(rsp_miss == em, t, "miss flag", REC_W'(rsp_miss), REC_W'(em));
          check(rsp_data == er, em ? "R4" : "R3", "record", rsp_data, er);
          check(rsp_face_done == ed, "R9", "face done", REC_W'(rsp_face_done), REC_W'(ed));
          if (ed) check(rsp_face_miss == ev, "R9", "face miss vector", REC_W'(rsp_face_miss), REC_W'(ev));
        end
      end
    end
  end

  task automatic drain();
    repeat (12) @(negedge clk);
  endtask

  task automatic check_counts(input string req);
    int eh, em;
    eh = (n_hit > CMAX) ? CMAX : n_hit;
    em = (n_miss > CMAX) ? CMAX : n_miss;
    check(hit_count == CNT_W'(eh), req, "hit_count", REC_W'(hit_count), REC_W'(eh));
    check(miss_count == CNT_W'(em), req, "miss_count", REC_W'(miss_count), REC_W'(em));
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1", "ready after reset", REC_W'(req_ready), REC_W'(1));
    check(!rsp_valid && !mem_req_valid, "R1", "idle outputs",
          REC_W'({rsp_valid, mem_req_valid}), REC_W'(0));
    check(hit_count == 0 && miss_count == 0, "R1", "counters zero",
          REC_W'({hit_count, miss_count}), REC_W'(0));

    // Triangle of fresh indices: all miss (R1), then overlapping strip faces.
    lookup(16'd1, "R1"); lookup(16'd2, "R1"); lookup(16'd3, "R1");
    lookup(16'd2, "R3"); lookup(16'd3, "R3"); lookup(16'd4, "R4");
    lookup(16'd4, "R3"); lookup(16'd3, "R3"); lookup(16'd5, "R4");
    // R6: top-bit aliasing
    lookup(16'h8001, "R6"); lookup(16'd1, "R6"); lookup(16'h8001, "R6");
    drain();
    check_counts("R7");

    // R5: fill with 16 new indices, keep hitting the oldest, then evict.
    for (int i = 0; i < ENTRIES; i++) lookup(16'(100 + i), "R5");
    for (int i = 0; i < 3; i++) lookup(16'd100, "R5");
    lookup(16'd116, "R5");
    lookup(16'd101, "R5");
    lookup(16'd100, "R5");
    drain();
    check_counts("R7");

    // R7: saturation with a long run of hits.
    for (int i = 0; i < 70; i++) lookup(16'd116, "R3");
    drain();
    check_counts("R7");
    check(hit_count == CNT_W'(CMAX), "R7", "hit saturation", REC_W'(hit_count), REC_W'(CMAX));

    // R8: clear, then while a hit response is produced at the same edge.
    clr_stats = 1'b1;
    @(negedge clk);
    clr_stats = 1'b0;
    check(hit_count == 0 && miss_count == 0, "R8", "cleared",
          REC_W'({hit_count, miss_count}), REC_W'(0));
    n_hit = 0; n_miss = 0;
    req_valid = 1'b1; req_index = 16'd116; clr_stats = 1'b1;
    exp_rec_q.push_back(rec_of(16'd116)); exp_miss_q.push_back(1'b0); exp_tag_q.push_back("R8");
    if (lane == 2) begin
      exp_done_q.push_back(1'b1); exp_vec_q.push_back({1'b0, acc}); lane = 0; acc = 2'b00;
    end else begin
      exp_done_q.push_back(1'b0); exp_vec_q.push_back(3'b000); acc[lane] = 1'b0; lane++;
    end
    @(negedge clk);
    req_valid = 1'b0; clr_stats = 1'b0;
    check(hit_count == 0, "R8", "clear beats increment", REC_W'(hit_count), REC_W'(0));
    lookup(16'd116, "R3");
    drain();
    check_counts("R7");

    // R10: every expected response was produced
    check(exp_rec_q.size() == 0, "R10", "responses outstanding",
          REC_W'(exp_rec_q.size()), REC_W'(0));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule